// File: doc/BRIEF.md
# Scan-Testable Mealy State Machine

This block is a three-state Mealy controller whose state flip-flops double as a serial scan chain. In functional mode it consumes one two-bit input symbol per clock, drives a two-bit output symbol combinationally from the current state and the applied symbol, and captures the next state on the clock edge. With scan enable raised, the state register stops updating functionally and acts as a shift register from the scan inputs to the scan outputs.

Because the state can be written and read serially, any single transition is tested on its own: shift in a source state, apply one symbol with scan enable low, observe the output symbol before the edge, clock once, then shift the captured state out and compare it. The machine never has to be steered into the source state through its symbol input, so the check reduces to the combinational next-state and output logic. A parameter splits the state bits into several equal parallel chains, which shortens the load and unload to one clock per chain bit.

Top module: `scan_fsm`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) loads state 1, code 2'b01.
- R2: States are coded 1 = 2'b01, 2 = 2'b10, 3 = 2'b11; input symbols A = 2'b00, B = 2'b01, C = 2'b10, E = 2'b11; output symbols none = 2'b00, c = 2'b01, d = 2'b10, f = 2'b11.
- R3: With scan_en low, one clock moves the state per the table: from 1: A→2/d, B→1/none, C→3/c, E→1/d; from 2: A→3/f, B→1/c, C→2/none, E→2/d; from 3: A→3/none, B→2/d, C→1/f, E→1/c.
- R4: With scan_en low, sym_out equals the table output for the current state and sym_in combinationally, before the capturing edge.
- R5: From state 2 the symbol A moves the machine to state 3 and produces f.
- R6: The unused code 2'b00 goes to state 1 on any symbol with output none.
- R7: With scan_en high each clock shifts every chain by one bit toward its MSB, scan_in[k] entering the LSB of chain k; no functional update happens.
- R8: scan_out[k] shows the MSB of chain k, so a full unload delivers the state MSB first.
- R9: While scan_en is high, sym_out is none (2'b00).
- R10: NUM_CHAINS splits the two state bits into equal chains, chain k holding bits [k*L +: L] with L = 2/NUM_CHAINS; with two chains a full load or unload takes one clock.
- R11: Reset takes priority over scan_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | High: shift mode; low: functional mode |
| scan_in | input | NUM_CHAINS | Serial input, one bit per chain |
| scan_out | output | NUM_CHAINS | Serial output, MSB of each chain |
| sym_in | input | 2 | Input symbol |
| sym_out | output | 2 | Mealy output symbol |
| state_view | output | 2 | Current state code |

## Verification
The assertions assume rst is driven high at the first clock edge and that scan_in, scan_en and sym_in change only away from the rising edge; the bench drives them a short delay after each edge. They also assume a two-bit state evenly divisible among the chains, so the bench builds only a one-chain and a two-chain instance. Functional-capture checks rely on sym_in being a known value whenever scan_en is low, which the bench keeps by always assigning a symbol before lowering scan_en.

// File: rtl/scan_fsm_pkg.sv
package scan_fsm_pkg;

  localparam int STATE_W = 2;
  localparam int SYM_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_LOST  = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b10,
    ST_THREE = 2'b11
  } state_t;

  typedef enum logic [SYM_W-1:0] {
    IN_A = 2'b00,
    IN_B = 2'b01,
    IN_C = 2'b10,
    IN_E = 2'b11
  } in_sym_t;

  typedef enum logic [SYM_W-1:0] {
    OUT_NONE = 2'b00,
    OUT_C    = 2'b01,
    OUT_D    = 2'b10,
    OUT_F    = 2'b11
  } out_sym_t;

  typedef struct packed {
    state_t   nxt;
    out_sym_t emit;
  } step_t;

  function automatic step_t mk(state_t n, out_sym_t o);
    step_t r;
    r.nxt  = n;
    r.emit = o;
    return r;
  endfunction

  // Transition and output table of the controller (R3, R5, R6)
  function automatic step_t fsm_step(state_t s, in_sym_t x);
    step_t r;
    r = mk(ST_ONE, OUT_NONE);
    unique case (s)
      ST_ONE: begin
        unique case (x)
          IN_A: r = mk(ST_TWO, OUT_D);
          IN_B: r = mk(ST_ONE, OUT_NONE);
          IN_C: r = mk(ST_THREE, OUT_C);
          IN_E: r = mk(ST_ONE, OUT_D);
          default: r = mk(ST_ONE, OUT_NONE);
        endcase
      end
      ST_TWO: begin
        unique case (x)
          IN_A: r = mk(ST_THREE, OUT_F);
          IN_B: r = mk(ST_ONE, OUT_C);
          IN_C: r = mk(ST_TWO, OUT_NONE);
          IN_E: r = mk(ST_TWO, OUT_D);
          default: r = mk(ST_ONE, OUT_NONE);
        endcase
      end
      ST_THREE: begin
        unique case (x)
          IN_A: r = mk(ST_THREE, OUT_NONE);
          IN_B: r = mk(ST_TWO, OUT_D);
          IN_C: r = mk(ST_ONE, OUT_F);
          IN_E: r = mk(ST_ONE, OUT_C);
          default: r = mk(ST_ONE, OUT_NONE);
        endcase
      end
      default: r = mk(ST_ONE, OUT_NONE);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/scan_fsm_logic.sv
module scan_fsm_logic
  import scan_fsm_pkg::*;
(
  input  logic [STATE_W-1:0] cur_state,
  input  logic [SYM_W-1:0]   sym,
  output logic [STATE_W-1:0] nxt_state,
  output logic [SYM_W-1:0]   emit_sym
);
  step_t st;

  always_comb begin
    st        = fsm_step(state_t'(cur_state), in_sym_t'(sym));
    nxt_state = st.nxt;
    emit_sym  = st.emit;
  end
endmodule

// File: rtl/scan_chain_reg.sv
module scan_chain_reg #(
  parameter int WIDTH  = 2,
  parameter int CHAINS = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [CHAINS-1:0] chain_in,
  input  logic [WIDTH-1:0]  load_val,
  output logic [CHAINS-1:0] chain_out,
  output logic [WIDTH-1:0]  q
);
  localparam int LEN = WIDTH / CHAINS;

  for (genvar k = 0; k < CHAINS; k++) begin : g_chain
    logic [LEN-1:0] seg;

    if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           seg <= RESET_VAL[k*LEN +: LEN];
        else if (shift_en) seg <= chain_in[k];
        else               seg <= load_val[k*LEN +: LEN];
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           seg <= RESET_VAL[k*LEN +: LEN];
        else if (shift_en) seg <= {seg[LEN-2:0], chain_in[k]};
        else               seg <= load_val[k*LEN +: LEN];
      end
    end

    assign q[k*LEN +: LEN] = seg;
    assign chain_out[k]    = seg[LEN-1];
  end
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_fsm_pkg::*;
#(
  parameter int NUM_CHAINS = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scan_en,
  input  logic [NUM_CHAINS-1:0] scan_in,
  output logic [NUM_CHAINS-1:0] scan_out,
  input  logic [SYM_W-1:0]      sym_in,
  output logic [SYM_W-1:0]      sym_out,
  output logic [STATE_W-1:0]    state_view
);
  localparam int CHAIN_LEN = STATE_W / NUM_CHAINS;

  logic [STATE_W-1:0] cur_state;
  logic [STATE_W-1:0] nxt_state;
  logic [SYM_W-1:0]   step_emit;
  logic               shifting;

  assign shifting = scan_en;

  scan_fsm_logic u_logic (
    .cur_state (cur_state),
    .sym       (sym_in),
    .nxt_state (nxt_state),
    .emit_sym  (step_emit)
  );

  scan_chain_reg #(
    .WIDTH     (STATE_W),
    .CHAINS    (NUM_CHAINS),
    .RESET_VAL (ST_ONE)
  ) u_state (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shifting),
    .chain_in  (scan_in),
    .load_val  (nxt_state),
    .chain_out (scan_out),
    .q         (cur_state)
  );

  assign sym_out    = shifting ? OUT_NONE : step_emit;
  assign state_view = cur_state;
endmodule

// File: rtl/scan_fsm_chk.sv
module scan_fsm_chk #(
  parameter int NUM_CHAINS = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scan_en,
  input logic [NUM_CHAINS-1:0] scan_in,
  input logic [1:0]            sym_out,
  input logic [1:0]            state_view,
  input logic [1:0]            nxt_state
);
  localparam int L = 2 / NUM_CHAINS;

  a_r1_reset_state: assert property (@(posedge clk) rst |=> state_view == 2'b01);

  a_r11_reset_over_scan: assert property (@(posedge clk) (rst && scan_en) |=> state_view == 2'b01);

  a_r3_func_capture: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> state_view == $past(nxt_state));

  a_r6_recover: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && state_view == 2'b00) |=> state_view == 2'b01);

  a_r9_idle_out: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> sym_out == 2'b00);

  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_k
    a_r7_shift_entry: assert property (@(posedge clk) disable iff (rst)
      scan_en |=> state_view[k*L] == $past(scan_in[k]));
  end
endmodule

bind scan_fsm scan_fsm_chk #(.NUM_CHAINS(NUM_CHAINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scan_en    (scan_en),
  .scan_in    (scan_in),
  .sym_out    (sym_out),
  .state_view (state_view),
  .nxt_state  (nxt_state)
);

// File: tb/test_scan_fsm.sv
module test_scan_fsm;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       scan_en = 1'b0, scan_en2 = 1'b0;
  logic [0:0] sin = '0;
  logic [1:0] sin2 = '0;
  logic [0:0] sout;
  logic [1:0] sout2;
  logic [1:0] sym = 2'b00, sym2 = 2'b00;
  logic [1:0] sout_sym, sout_sym2, view, view2;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  scan_fsm #(.NUM_CHAINS(1)) i_scan_fsm (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(sin), .scan_out(sout),
    .sym_in(sym), .sym_out(sout_sym), .state_view(view));

  scan_fsm #(.NUM_CHAINS(2)) i_scan_fsm_dual (
    .clk(clk), .rst(rst), .scan_en(scan_en2), .scan_in(sin2), .scan_out(sout2),
    .sym_in(sym2), .sym_out(sout_sym2), .state_view(view2));

  // expected {next, output} per R2/R3/R6
  function automatic logic [3:0] golden(logic [1:0] s, logic [1:0] x);
    logic [3:0] r;
    r = 4'b0100;
    if (s == 2'd1) r = (x == 0) ? 4'b1010 : (x == 1) ? 4'b0100 : (x == 2) ? 4'b1101 : 4'b0110;
    if (s == 2'd2) r = (x == 0) ? 4'b1111 : (x == 1) ? 4'b0101 : (x == 2) ? 4'b1000 : 4'b1010;
    if (s == 2'd3) r = (x == 0) ? 4'b1100 : (x == 1) ? 4'b1010 : (x == 2) ? 4'b0111 : 4'b0101;
    return r;
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #2;
  endtask

  task automatic one_transition(input logic [1:0] s, input logic [1:0] x);
    logic [3:0] g;
    string tag;
    g = golden(s, x);
    tag = (s == 2 && x == 0) ? "R5" : (s == 0) ? "R6" : "R3";
    scan_en = 1'b1;
    for (int i = 1; i >= 0; i--) begin
      sin[0] = s[i];
      edge_step();
    end
    chk(view, s, "R7 load");
    scan_en = 1'b0;
    sym = x;
    @(negedge clk);
    chk(sout_sym, g[1:0], {tag, " R4 output"});
    edge_step();
    chk(view, g[3:2], {tag, " next state"});
    scan_en = 1'b1;
    sin[0] = 1'b0;
    @(negedge clk);
    chk(sout, g[3], "R8 unload msb");
    chk(sout_sym, 2'b00, "R9 idle output");
    edge_step();
    @(negedge clk);
    chk(sout, g[2], "R8 unload lsb");
    edge_step();
    chk(view, 2'b00, "R7 shift in zeros");
  endtask

  initial begin
    edge_step();
    edge_step();
    chk(view, 2'b01, "R1 reset state");
    rst = 1'b0;
    sym = 2'b00;
    @(negedge clk);
    chk(sout_sym, 2'b10, "R4 output after reset");
    chk(view2, 2'b01, "R1 reset state dual");

    for (int s = 0; s < 4; s++)
      for (int x = 0; x < 4; x++)
        one_transition(s[1:0], x[1:0]);

    // R11: reset wins over shift
    scan_en = 1'b1;
    sin[0] = 1'b0;
    rst = 1'b1;
    edge_step();
    chk(view, 2'b01, "R11 reset over scan");
    rst = 1'b0;
    scan_en = 1'b0;

    // R10: two chains, one-clock load and unload
    for (int s = 1; s < 4; s++)
      for (int x = 0; x < 4; x++) begin
        logic [3:0] g;
        g = golden(s[1:0], x[1:0]);
        scan_en2 = 1'b1;
        sin2 = s[1:0];
        edge_step();
        chk(view2, s[1:0], "R10 one clock load");
        scan_en2 = 1'b0;
        sym2 = x[1:0];
        edge_step();
        scan_en2 = 1'b1;
        sin2 = 2'b00;
        @(negedge clk);
        chk(sout2, g[3:2], "R10 parallel unload");
        edge_step();
      end
    scan_en2 = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule